// File: doc/BRIEF.md
# Channel Command Word Decoder

This block sits between a processor's programmed I/O bus and a distributor that serves seven peripheral channels, each run by its own small sequencer. Every bus access carries an 8-bit device-address byte. The top nibble picks one of four distributors through a two-bit strap. Bits 3:1 name the channel, and bit 0 chooses between a control transfer and a data transfer. Accesses for another distributor, or for channel number 0, are dropped without any effect.

A control write carries a 16-bit command word. Bit 8 pulses a reset to the addressed sequencer. Bit 9 asks for a branch: the sequencer receives a one-cycle strobe with the 4-bit entry address from bits 7:4, and bits 13:11 are stored for that channel. A branch is accepted only while the sequencer reports that it is idle. A refused branch sets a sticky error flag for that channel, and a later reset command clears the flag. Bits 3:0 are mode lines that stay on the channel until the next control write. A control read returns the channel's status byte. Data writes and data reads move one byte to or from the channel.

All outputs are registered. Each strobe and each piece of read data appears exactly one clock after the cycle in which the bus access is presented.

Top module: `pio_cmd_decoder`

## Requirements
- R1: An access is accepted only when busAddr[7:6] is 2'b11 and busAddr[5:4] equals strapSel. Any other access causes no reset strobe, no branch strobe, no data strobe, no read response and no change to stored state.
- R2: An access whose channel field busAddr[3:1] is 0 is ignored in the same way. Channel numbers 1 to 7 map to output index 0 to 6.
- R3: A control write (busAddr[0]=1) with command bit 8 set pulses chanReset for the addressed channel for one cycle, one clock after the access, and clears that channel's error flag.
- R4: A control write with bit 9 set, bit 8 clear and chanIdle high for the channel pulses chanBranch for that channel for one cycle, one clock later. In the same cycle branchAddr takes command bits 7:4, and chanCtl for that channel takes bits 13:11.
- R5: A branch request to a channel whose chanIdle is low produces no branch strobe and leaves branchAddr and chanCtl unchanged. It sets that channel's chanErr bit, which stays set until a reset command reaches the channel.
- R6: When bits 8 and 9 are both set, the reset takes effect, and no branch strobe, chanCtl update or error occurs.
- R7: Every accepted control write loads command bits 3:0 into that channel's 4-bit chanMode field. Other accesses leave the field unchanged.
- R8: An accepted read raises busRdValid for one cycle, one clock later. busRdData is the channel's chanStatus byte when busAddr[0]=1 and its chanRdData byte when busAddr[0]=0. busRdData is 0 when busRdValid is low.
- R9: An accepted data write (busAddr[0]=0) pulses dataWrStb for the channel for one cycle, one clock later, with dataWrByte equal to busWdata[7:0].
- R10: After reset, all strobes, mode, control and error state, branchAddr, dataWrByte and the read outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| strapSel | input | 2 | Distributor number (code 0xC + strapSel) |
| busValid | input | 1 | Access presented this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Device-address byte |
| busWdata | input | 16 | Command word or data byte (low 8 bits) |
| chanIdle | input | 7 | Sequencer at idle address, per channel |
| chanStatus | input | 56 | Status byte per channel, channel 1 in bits 7:0 |
| chanRdData | input | 56 | Read data byte per channel |
| busRdValid | output | 1 | Read response valid |
| busRdData | output | 8 | Read response byte |
| chanReset | output | 7 | One-cycle reset strobe per channel |
| chanBranch | output | 7 | One-cycle branch strobe per channel |
| branchAddr | output | 4 | Entry address for the last branch |
| chanMode | output | 28 | Static mode lines, 4 per channel |
| chanCtl | output | 21 | Stored control bits, 3 per channel |
| chanErr | output | 7 | Sticky refused-branch flag per channel |
| dataWrStb | output | 7 | One-cycle data write strobe per channel |
| dataWrByte | output | 8 | Byte of the last data write |

## Verification
The properties assume that busValid, busWrite, busAddr, strapSel and chanIdle are steady across each rising edge and never X while reset is released. They also assume that strapSel changes only while no access is in flight, because the quiet-on-mismatch check compares the address against the strap sampled with it. The stimulus drives every input on the falling edge and changes the strap only between complete sweeps. Each access is held for exactly one cycle and followed by an idle cycle, so each response is compared against that one access alone.

// File: rtl/pio_cmd_pkg.sv
package pio_cmd_pkg;
  localparam int NUM_CH  = 7;
  localparam int CH_W    = 3;
  localparam int BYTE_W  = 8;
  localparam int CMD_W   = 16;
  localparam int MODE_W  = 4;
  localparam int CTL_W   = 3;
  localparam int BADDR_W = 4;
  localparam int STRAP_W = 2;

  // Command word field positions
  localparam int MODE_LSB  = 0;
  localparam int BADDR_LSB = 4;
  localparam int RST_BIT   = 8;
  localparam int BR_BIT    = 9;
  localparam int CTL_LSB   = 11;

  typedef struct packed {
    logic [NUM_CH-1:0] chSel;
    logic [CH_W-1:0]   chIdx;
    logic              cmdWr;
    logic              resetReq;
    logic              branchGo;
    logic              branchErr;
    logic              dataWr;
    logic              statRd;
    logic              dataRd;
  } dec_strobe_t;
endpackage

// File: rtl/pio_cmd_ctrl.sv
module pio_cmd_ctrl
  import pio_cmd_pkg::*;
(
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [BYTE_W-1:0]   busAddr,
  input  logic [CMD_W-1:0]    busWdata,
  input  logic [STRAP_W-1:0]  strapSel,
  input  logic [NUM_CH-1:0]   chanIdle,
  output dec_strobe_t         stb
);
  localparam int EXT_N = 2**CH_W;

  logic              hit;
  logic              useful;
  logic [CH_W-1:0]   chNum;
  logic [CH_W-1:0]   idx;
  logic [EXT_N-1:0]  idleExt;
  logic              isCtl;
  logic              brReq;

  always_comb begin
    hit     = busValid && (busAddr[7:6] == 2'b11) && (busAddr[5:4] == strapSel);
    chNum   = busAddr[CH_W:1];
    useful  = hit && (chNum != '0);
    idx     = useful ? chNum - CH_W'(1) : '0;
    idleExt = EXT_N'(chanIdle);
    isCtl   = busAddr[0];
    brReq   = busWdata[BR_BIT] && !busWdata[RST_BIT];

    stb = '0;
    if (useful) begin
      stb.chSel     = NUM_CH'(1) << idx;
      stb.chIdx     = idx;
      stb.cmdWr     = busWrite && isCtl;
      stb.resetReq  = busWrite && isCtl && busWdata[RST_BIT];
      stb.branchGo  = busWrite && isCtl && brReq && idleExt[idx];
      stb.branchErr = busWrite && isCtl && brReq && !idleExt[idx];
      stb.dataWr    = busWrite && !isCtl;
      stb.statRd    = !busWrite && isCtl;
      stb.dataRd    = !busWrite && !isCtl;
    end
  end
endmodule

// File: rtl/pio_cmd_dpath.sv
module pio_cmd_dpath
  import pio_cmd_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  dec_strobe_t                stb,
  input  logic [CMD_W-1:0]           busWdata,
  input  logic [NUM_CH*BYTE_W-1:0]   chanStatus,
  input  logic [NUM_CH*BYTE_W-1:0]   chanRdData,
  output logic                       busRdValid,
  output logic [BYTE_W-1:0]          busRdData,
  output logic [NUM_CH-1:0]          chanReset,
  output logic [NUM_CH-1:0]          chanBranch,
  output logic [BADDR_W-1:0]         branchAddr,
  output logic [NUM_CH*MODE_W-1:0]   chanMode,
  output logic [NUM_CH*CTL_W-1:0]    chanCtl,
  output logic [NUM_CH-1:0]          chanErr,
  output logic [NUM_CH-1:0]          dataWrStb,
  output logic [BYTE_W-1:0]          dataWrByte
);
  logic [BYTE_W-1:0] statByte;
  logic [BYTE_W-1:0] dataByte;

  always_comb begin
    statByte = chanStatus[stb.chIdx*BYTE_W +: BYTE_W];
    dataByte = chanRdData[stb.chIdx*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanReset  <= '0;
      chanBranch <= '0;
      dataWrStb  <= '0;
      busRdValid <= 1'b0;
      busRdData  <= '0;
      branchAddr <= '0;
      dataWrByte <= '0;
    end else begin
      chanReset  <= stb.resetReq ? stb.chSel : '0;
      chanBranch <= stb.branchGo ? stb.chSel : '0;
      dataWrStb  <= stb.dataWr   ? stb.chSel : '0;
      busRdValid <= stb.statRd || stb.dataRd;
      busRdData  <= stb.statRd ? statByte : (stb.dataRd ? dataByte : '0);
      if (stb.branchGo) branchAddr <= busWdata[BADDR_LSB +: BADDR_W];
      if (stb.dataWr)   dataWrByte <= busWdata[BYTE_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chanMode[g*MODE_W +: MODE_W] <= '0;
        chanCtl[g*CTL_W +: CTL_W]    <= '0;
        chanErr[g]                   <= 1'b0;
      end else if (stb.chSel[g]) begin
        if (stb.cmdWr)     chanMode[g*MODE_W +: MODE_W] <= busWdata[MODE_LSB +: MODE_W];
        if (stb.branchGo)  chanCtl[g*CTL_W +: CTL_W]    <= busWdata[CTL_LSB +: CTL_W];
        if (stb.resetReq)  chanErr[g] <= 1'b0;
        else if (stb.branchErr) chanErr[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pio_cmd_decoder.sv
module pio_cmd_decoder
  import pio_cmd_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [STRAP_W-1:0]         strapSel,
  input  logic                       busValid,
  input  logic                       busWrite,
  input  logic [BYTE_W-1:0]          busAddr,
  input  logic [CMD_W-1:0]           busWdata,
  input  logic [NUM_CH-1:0]          chanIdle,
  input  logic [NUM_CH*BYTE_W-1:0]   chanStatus,
  input  logic [NUM_CH*BYTE_W-1:0]   chanRdData,
  output logic                       busRdValid,
  output logic [BYTE_W-1:0]          busRdData,
  output logic [NUM_CH-1:0]          chanReset,
  output logic [NUM_CH-1:0]          chanBranch,
  output logic [BADDR_W-1:0]         branchAddr,
  output logic [NUM_CH*MODE_W-1:0]   chanMode,
  output logic [NUM_CH*CTL_W-1:0]    chanCtl,
  output logic [NUM_CH-1:0]          chanErr,
  output logic [NUM_CH-1:0]          dataWrStb,
  output logic [BYTE_W-1:0]          dataWrByte
);
  dec_strobe_t stb;

  pio_cmd_ctrl i_ctrl (
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .strapSel (strapSel),
    .chanIdle (chanIdle),
    .stb      (stb)
  );

  pio_cmd_dpath i_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .busWdata   (busWdata),
    .chanStatus (chanStatus),
    .chanRdData (chanRdData),
    .busRdValid (busRdValid),
    .busRdData  (busRdData),
    .chanReset  (chanReset),
    .chanBranch (chanBranch),
    .branchAddr (branchAddr),
    .chanMode   (chanMode),
    .chanCtl    (chanCtl),
    .chanErr    (chanErr),
    .dataWrStb  (dataWrStb),
    .dataWrByte (dataWrByte)
  );
endmodule

// File: rtl/pio_cmd_checker.sv
module pio_cmd_checker
  import pio_cmd_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic [STRAP_W-1:0]       strapSel,
  input logic                     busValid,
  input logic                     busWrite,
  input logic [BYTE_W-1:0]        busAddr,
  input logic [NUM_CH-1:0]        chanIdle,
  input logic                     busRdValid,
  input logic [NUM_CH-1:0]        chanReset,
  input logic [NUM_CH-1:0]        chanBranch,
  input logic [NUM_CH*MODE_W-1:0] chanMode,
  input logic [NUM_CH-1:0]        chanErr,
  input logic [NUM_CH-1:0]        dataWrStb
);
  a_r1_foreign_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && (busAddr[7:4] != {2'b11, strapSel}))
    |=> (chanReset == '0 && chanBranch == '0 && dataWrStb == '0 && !busRdValid));

  a_r2_chan_zero_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && (busAddr[3:1] == 3'd0))
    |=> (chanReset == '0 && chanBranch == '0 && dataWrStb == '0 && !busRdValid));

  a_r4_branch_only_idle: assert property (@(posedge clk) disable iff (!rstN)
    (chanBranch != '0) |-> ((chanBranch & $past(chanIdle)) == chanBranch));

  a_r4_strobe_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chanBranch) && $onehot0(chanReset) && $onehot0(dataWrStb));

  a_r6_reset_excludes_branch: assert property (@(posedge clk) disable iff (!rstN)
    !((|chanReset) && (|chanBranch)));

  a_r5_err_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    ((chanErr & ~$past(chanErr)) != '0) |-> $past(busValid && busWrite));

  a_r7_mode_hold: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |=> $stable(chanMode));
endmodule

bind pio_cmd_decoder pio_cmd_checker i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .strapSel   (strapSel),
  .busValid   (busValid),
  .busWrite   (busWrite),
  .busAddr    (busAddr),
  .chanIdle   (chanIdle),
  .busRdValid (busRdValid),
  .chanReset  (chanReset),
  .chanBranch (chanBranch),
  .chanMode   (chanMode),
  .chanErr    (chanErr),
  .dataWrStb  (dataWrStb)
);

// File: tb/test_pio_cmd_decoder.sv
module test_pio_cmd_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  strapSel = 2'd3;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [6:0]  chanIdle = '0;
  logic [55:0] chanStatus;
  logic [55:0] chanRdData;
  logic        busRdValid;
  logic [7:0]  busRdData;
  logic [6:0]  chanReset, chanBranch, chanErr, dataWrStb;
  logic [3:0]  branchAddr;
  logic [27:0] chanMode;
  logic [20:0] chanCtl;
  logic [7:0]  dataWrByte;

  int nChecks = 0;
  int nErr = 0;
  bit done = 0;

  // expected state
  logic [27:0] eMode = '0;
  logic [20:0] eCtl = '0;
  logic [6:0]  eErr = '0;
  logic [3:0]  eBrAddr = '0;
  logic [7:0]  eDataByte = '0;

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 7; i++) begin
      chanStatus[i*8 +: 8] = 8'h30 + 8'(i);
      chanRdData[i*8 +: 8] = 8'hA0 + 8'(i);
    end
  end

  pio_cmd_decoder i_pio_cmd_decoder (
    .clk(clk), .rstN(rstN), .strapSel(strapSel), .busValid(busValid),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .chanIdle(chanIdle), .chanStatus(chanStatus), .chanRdData(chanRdData),
    .busRdValid(busRdValid), .busRdData(busRdData), .chanReset(chanReset),
    .chanBranch(chanBranch), .branchAddr(branchAddr), .chanMode(chanMode),
    .chanCtl(chanCtl), .chanErr(chanErr), .dataWrStb(dataWrStb),
    .dataWrByte(dataWrByte)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=%h expected=%h (strap=%0d addr=%h wr=%0d wd=%h idle=%b)",
               req, act, exp, strapSel, busAddr, busWrite, busWdata, chanIdle);
    end
  endtask

  task automatic access(input logic wr, input logic [7:0] a, input logic [15:0] wd,
                        input logic [6:0] idle);
    logic       hit, useful, isCtl;
    int         ix;
    logic [6:0] sel, eRst, eBr, eDst;
    logic       eRdV;
    logic [7:0] eRd;
    string      brReq;
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busAddr = a; busWdata = wd; chanIdle = idle;
    hit    = (a[7:4] == {2'b11, strapSel});
    useful = hit && (a[3:1] != 3'd0);
    ix     = int'(a[3:1]) - 1;
    isCtl  = a[0];
    sel    = useful ? (7'd1 << ix) : 7'd0;
    eRst = '0; eBr = '0; eDst = '0; eRdV = 1'b0; eRd = '0;
    if (useful && wr && isCtl) begin
      eMode[ix*4 +: 4] = wd[3:0];
      if (wd[8]) begin
        eRst = sel;
        eErr[ix] = 1'b0;
      end else if (wd[9]) begin
        if (idle[ix]) begin
          eBr = sel;
          eBrAddr = wd[7:4];
          eCtl[ix*3 +: 3] = wd[13:11];
        end else begin
          eErr[ix] = 1'b1;
        end
      end
    end
    if (useful && wr && !isCtl) begin
      eDst = sel;
      eDataByte = wd[7:0];
    end
    if (useful && !wr) begin
      eRdV = 1'b1;
      eRd  = isCtl ? (8'h30 + 8'(ix)) : (8'hA0 + 8'(ix));
    end
    brReq = (wd[8] && wd[9]) ? "R6" : (idle[ix < 0 ? 0 : ix] ? "R4" : "R5");
    @(negedge clk);
    busValid = 1'b0;
    if (!hit)
      check("R1 quiet", 64'({chanReset, chanBranch, dataWrStb, busRdValid}), 64'd0);
    else if (!useful)
      check("R2 quiet", 64'({chanReset, chanBranch, dataWrStb, busRdValid}), 64'd0);
    check("R3 reset strobe", 64'(chanReset), 64'(eRst));
    check({brReq, " branch strobe"}, 64'(chanBranch), 64'(eBr));
    check("R4 branch address", 64'(branchAddr), 64'(eBrAddr));
    check("R4 stored control bits", 64'(chanCtl), 64'(eCtl));
    check("R5 error flags", 64'(chanErr), 64'(eErr));
    check("R7 mode lines", 64'(chanMode), 64'(eMode));
    check("R9 data strobe", 64'(dataWrStb), 64'(eDst));
    check("R9 data byte", 64'(dataWrByte), 64'(eDataByte));
    check("R8 read valid", 64'(busRdValid), 64'(eRdV));
    check("R8 read data", 64'(busRdData), 64'(eRd));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nErr++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset outputs", 64'({chanReset, chanBranch, dataWrStb, busRdValid, busRdData}), 64'd0);
    check("R10 reset state", 64'({chanMode, chanCtl, chanErr, branchAddr, dataWrByte}), 64'd0);
    rstN = 1'b1;
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      strapSel = 2'(3 - s);
      for (int a = 0; a < 256; a++) begin
        for (int k = 0; k < 6; k++) begin
          logic [7:0]  ad;
          logic [15:0] wd;
          logic [6:0]  idle;
          ad = 8'(a);
          idle = 7'((7'b0110101 << ((s + k + a) % 7)) | (7'b0110101 >> (7 - (s + k + a) % 7)));
          wd = {2'b00, ad[2:0] ^ 3'(k), 1'b0, k[0], k[1],
                ad[7:4] ^ ad[3:0], ad[3:0] + 4'(k)};
          if (k < 4) access(1'b1, ad, wd, idle);
          else if (k == 4) access(1'b0, ad, wd, idle);
          else access(1'b1, ad ^ 8'h01, wd, idle); // R9/R7 opposite function code
        end
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule